// File: doc/BRIEF.md
# Set-Aside Queue Stop/Go Controller

At an input port, packets headed for a congested point are parked in dynamically assigned set-aside queues. Each queue has one line in a small table: a routing key that names the congested point, and the state of the line. This block keeps that table's flow-control state. On every packet move made by the post-processing logic, it checks two queues. The queue that receives the packet is checked against a high-water mark. The queue that gives up the packet is checked against a low-water mark. When a mark is crossed, the block queues a backward stop (Xoff) or go (Xon) notification that carries the line's key. A per-line "stop sent" flag makes sure each stop is matched by exactly one go.

The block also takes stop and go notices that the local output side forwards toward this port. A stop notice halts the line whose key matches it, or claims a free line already halted. A go notice releases every matching line. A halted line raises its bit on `line_stop`, and the forwarding logic must not send from that queue. The congestion detector claims lines through the allocate port. The queue manager frees lines through the release port. A release of a line whose stop flag is set first queues the go notice that the upstream side is still waiting for.

Each line runs a three-state machine: `LN_FREE` (unclaimed), `LN_RUN` (claimed, may forward) and `LN_HALT` (claimed, stopped). The transitions are:
- `LN_FREE` to `LN_RUN` on an allocate request.
- `LN_FREE` to `LN_HALT` on a stop notice for an unknown key.
- `LN_RUN` to `LN_HALT` on a matching stop notice.
- `LN_HALT` to `LN_RUN` on a matching go notice.
- `LN_RUN` to `LN_FREE` on a release.

Outgoing notices wait in a first-word-fall-through queue that accepts up to two entries per cycle.

Top module: `saqfc_ctrl`

## Requirements
- R1: A move whose destination is a claimed set-aside queue (`mv_dst_saq`=1) with a count strictly above XOFF_TH (default 10), while that line's stop flag is clear, queues a stop notice (`nt_xon`=0) with that line's key and sets the flag.
- R2: No stop notice is queued while the destination line's stop flag is already set, when the count equals XOFF_TH, or when the destination is the cold queue (`mv_dst_saq`=0).
- R3: A move whose source is a claimed set-aside queue (`mv_src_saq`=1) with a count strictly below XON_TH (default 5), while that line's stop flag is set, queues a go notice (`nt_xon`=1) with that line's key and clears the flag. The notice is not queued when the flag is clear or when the count equals XON_TH.
- R4: When one move produces both notices, the stop notice leaves the block before the go notice.
- R5: A local stop notice (`loc_valid`=1, `loc_is_xon`=0) halts every claimed line with an equal key. If no line matches, the lowest-numbered free line is claimed in the halted state with the notice's key. If no line is free, the notice has no effect.
- R6: A local go notice (`loc_is_xon`=1) returns every claimed line with an equal key to the running state.
- R7: An allocate request claims the lowest-numbered free line in the running state with a clear stop flag. It is ignored if a claimed line already holds the key, or if `loc_valid` is high in the same cycle.
- R8: `line_stop[i]` is high exactly while line i is halted. A release request for a halted line is ignored.
- R9: A release frees the line. If the line's stop flag is set, a go notice with its key is queued. A release is ignored when `mv_valid` or `loc_valid` is high in the same cycle.
- R10: Notices leave in the order queued. The head is held until `nt_ready` takes it. When the notice queue lacks room, the stop flag is left unchanged, so a later move raises the same notice again.
- R11: After reset every line is free, no line is stopped and no notice is pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mv_valid | input | 1 | A packet move happens this cycle |
| mv_dst_saq | input | 1 | Destination is a set-aside queue (0 = cold queue) |
| mv_dst_idx | input | IDX_W | Destination line index |
| mv_dst_cnt | input | CNT_W | Destination occupancy after the move |
| mv_src_saq | input | 1 | Source is a set-aside queue (0 = cold queue) |
| mv_src_idx | input | IDX_W | Source line index |
| mv_src_cnt | input | CNT_W | Source occupancy after the move |
| loc_valid | input | 1 | Local stop/go notice present |
| loc_is_xon | input | 1 | Local notice kind, 1 = go, 0 = stop |
| loc_key | input | KEY_W | Key of the local notice |
| alloc_valid | input | 1 | Claim a line for a detected congested point |
| alloc_key | input | KEY_W | Key for the claimed line |
| dl_valid | input | 1 | Release a line |
| dl_idx | input | IDX_W | Line to release |
| nt_ready | input | 1 | Upstream takes the head notice |
| line_valid | output | NLINES | Line is claimed |
| line_stop | output | NLINES | Line is halted; its queue may not forward |
| nt_valid | output | 1 | A notice is pending |
| nt_xon | output | 1 | Head notice kind, 1 = go, 0 = stop |
| nt_key | output | KEY_W | Key carried by the head notice |

## Verification
On every cycle, the bound checker confirms several properties:
- A local stop or go notice leaves each matching line halted or running on the next cycle.
- A line never leaves the claimed set while halted, nor in a cycle with a move or a local notice.
- A stop flag only rises after a qualifying move into that line.
- The head notice stays still while it is not taken, and the queue never holds more than its depth.

Other behaviour needs the bench's scenarios:
- The exact threshold edges.
- The ordering of paired notices.
- Duplicate-key and full-table handling.
- Retry after a stop notice is dropped for lack of room.
- The go notice raised by releasing a line that still owes one.

// File: rtl/saqfc_pkg.sv
package saqfc_pkg;

    // Per-line life cycle of a set-aside queue entry
    typedef enum logic [1:0] {
        LN_FREE = 2'd0,
        LN_RUN  = 2'd1,
        LN_HALT = 2'd2
    } ln_state_e;

endpackage

// File: rtl/saqfc_line.sv
module saqfc_line
    import saqfc_pkg::*;
#(
    parameter int KEY_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             alloc_run,
    input  logic             alloc_halt,
    input  logic             set_stop,
    input  logic             clr_stop,
    input  logic             set_sent,
    input  logic             clr_sent,
    input  logic             release_i,
    input  logic [KEY_W-1:0] key_in,
    output logic             is_valid,
    output logic             is_stopped,
    output logic             sent,
    output logic [KEY_W-1:0] key
);

    ln_state_e        state_q, state_d;
    logic             sent_q;
    logic [KEY_W-1:0] key_q;
    logic             claim;

    assign claim = (state_q == LN_FREE) && (alloc_run || alloc_halt);

    // next-state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            LN_FREE: begin
                if (alloc_halt)     state_d = LN_HALT;
                else if (alloc_run) state_d = LN_RUN;
            end
            LN_RUN: begin
                if (release_i)     state_d = LN_FREE;
                else if (set_stop) state_d = LN_HALT;
            end
            LN_HALT: begin
                if (clr_stop) state_d = LN_RUN;
            end
            default: state_d = LN_FREE;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= LN_FREE;
        else        state_q <= state_d;
    end

    // key and stop-sent flag
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sent_q <= 1'b0;
            key_q  <= '0;
        end else begin
            if (claim) key_q <= key_in;
            if (claim || release_i) sent_q <= 1'b0;
            else if (set_sent)      sent_q <= 1'b1;
            else if (clr_sent)      sent_q <= 1'b0;
        end
    end

    // outputs
    always_comb begin
        is_valid   = 1'b0;
        is_stopped = 1'b0;
        unique case (state_q)
            LN_FREE: ;
            LN_RUN:  is_valid = 1'b1;
            LN_HALT: begin
                is_valid   = 1'b1;
                is_stopped = 1'b1;
            end
            default: ;
        endcase
    end

    assign sent = sent_q;
    assign key  = key_q;

endmodule

// File: rtl/saqfc_nfifo.sv
module saqfc_nfifo #(
    parameter int W     = 9,
    parameter int DEPTH = 4,
    localparam int PTR_W = $clog2(DEPTH),
    localparam int LVL_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             push_a,
    input  logic [W-1:0]     data_a,
    input  logic             push_b,
    input  logic [W-1:0]     data_b,
    input  logic             pop,
    output logic             head_valid,
    output logic [W-1:0]     head_data,
    output logic [LVL_W-1:0] level
);

    logic [W-1:0]     mem_q [DEPTH];
    logic [PTR_W-1:0] wr_q, rd_q;
    logic [LVL_W-1:0] lvl_q;

    always_ff @(posedge clk) begin
        if (push_a) mem_q[wr_q] <= data_a;
        if (push_b) mem_q[wr_q + PTR_W'(1)] <= data_b;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_q  <= '0;
            rd_q  <= '0;
            lvl_q <= '0;
        end else begin
            wr_q  <= wr_q + PTR_W'(push_a) + PTR_W'(push_b);
            if (pop) rd_q <= rd_q + PTR_W'(1);
            lvl_q <= lvl_q + LVL_W'(push_a) + LVL_W'(push_b) - LVL_W'(pop);
        end
    end

    assign head_valid = (lvl_q != '0);
    assign head_data  = mem_q[rd_q];
    assign level      = lvl_q;

endmodule

// File: rtl/saqfc_ctrl.sv
module saqfc_ctrl #(
    parameter int NLINES   = 4,
    parameter int KEY_W    = 8,
    parameter int CNT_W    = 7,
    parameter int XOFF_TH  = 10,
    parameter int XON_TH   = 5,
    parameter int NQ_DEPTH = 4,
    localparam int IDX_W = $clog2(NLINES),
    localparam int LVL_W = $clog2(NQ_DEPTH + 1),
    localparam int ENT_W = KEY_W + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              mv_valid,
    input  logic              mv_dst_saq,
    input  logic [IDX_W-1:0]  mv_dst_idx,
    input  logic [CNT_W-1:0]  mv_dst_cnt,
    input  logic              mv_src_saq,
    input  logic [IDX_W-1:0]  mv_src_idx,
    input  logic [CNT_W-1:0]  mv_src_cnt,
    input  logic              loc_valid,
    input  logic              loc_is_xon,
    input  logic [KEY_W-1:0]  loc_key,
    input  logic              alloc_valid,
    input  logic [KEY_W-1:0]  alloc_key,
    input  logic              dl_valid,
    input  logic [IDX_W-1:0]  dl_idx,
    input  logic              nt_ready,
    output logic [NLINES-1:0] line_valid,
    output logic [NLINES-1:0] line_stop,
    output logic              nt_valid,
    output logic              nt_xon,
    output logic [KEY_W-1:0]  nt_key
);

    logic [NLINES-1:0] ln_valid, ln_stop, ln_sent;
    logic [KEY_W-1:0]  ln_key [NLINES];
    logic [NLINES-1:0] loc_hit, alloc_hit;
    logic              free_any;
    logic [IDX_W-1:0]  free_idx;
    logic [LVL_W-1:0]  fq_level, room;
    logic              xoff_cond, xon_cond, xoff_go, xon_go;
    logic              dl_go, dl_xon, loc_new, al_go;
    logic              push_a, push_b, pop;
    logic [ENT_W-1:0]  data_a, data_b, head;

    // key compare per line
    for (genvar i = 0; i < NLINES; i++) begin : g_hit
        assign loc_hit[i]   = ln_valid[i] && (ln_key[i] == loc_key);
        assign alloc_hit[i] = ln_valid[i] && (ln_key[i] == alloc_key);
    end

    // lowest-numbered free line
    always_comb begin
        free_any = 1'b0;
        free_idx = '0;
        for (int i = NLINES - 1; i >= 0; i--) begin
            if (!ln_valid[i]) begin
                free_any = 1'b1;
                free_idx = IDX_W'(i);
            end
        end
    end

    assign room = LVL_W'(NQ_DEPTH) - fq_level;

    // hysteresis checks on a packet move
    assign xoff_cond = mv_valid && mv_dst_saq && ln_valid[mv_dst_idx]
                    && !ln_sent[mv_dst_idx] && (mv_dst_cnt > CNT_W'(XOFF_TH));
    assign xon_cond  = mv_valid && mv_src_saq && ln_valid[mv_src_idx]
                    && ln_sent[mv_src_idx] && (mv_src_cnt < CNT_W'(XON_TH));
    assign xoff_go   = xoff_cond && (room != '0);
    assign xon_go    = xon_cond && (room >= (xoff_go ? LVL_W'(2) : LVL_W'(1)));

    // release, local notice, allocate
    assign dl_go   = dl_valid && !mv_valid && !loc_valid && ln_valid[dl_idx]
                  && !ln_stop[dl_idx] && (!ln_sent[dl_idx] || (room != '0));
    assign dl_xon  = dl_go && ln_sent[dl_idx];
    assign loc_new = loc_valid && !loc_is_xon && !(|loc_hit) && free_any;
    assign al_go   = alloc_valid && !loc_valid && !(|alloc_hit) && free_any;

    // notice queue entries: {is_xon, key}
    always_comb begin
        push_a = xoff_go || xon_go || dl_xon;
        push_b = xoff_go && xon_go;
        data_b = {1'b1, ln_key[mv_src_idx]};
        if (xoff_go)     data_a = {1'b0, ln_key[mv_dst_idx]};
        else if (xon_go) data_a = {1'b1, ln_key[mv_src_idx]};
        else             data_a = {1'b1, ln_key[dl_idx]};
    end

    for (genvar i = 0; i < NLINES; i++) begin : g_line
        saqfc_line #(.KEY_W(KEY_W)) u_line (
            .clk        (clk),
            .rst_n      (rst_n),
            .alloc_run  (al_go && (free_idx == IDX_W'(i))),
            .alloc_halt (loc_new && (free_idx == IDX_W'(i))),
            .set_stop   (loc_valid && !loc_is_xon && loc_hit[i]),
            .clr_stop   (loc_valid && loc_is_xon && loc_hit[i]),
            .set_sent   (xoff_go && (mv_dst_idx == IDX_W'(i))),
            .clr_sent   (xon_go && (mv_src_idx == IDX_W'(i))),
            .release_i  (dl_go && (dl_idx == IDX_W'(i))),
            .key_in     (loc_new ? loc_key : alloc_key),
            .is_valid   (ln_valid[i]),
            .is_stopped (ln_stop[i]),
            .sent       (ln_sent[i]),
            .key        (ln_key[i])
        );
    end

    assign pop = nt_ready && nt_valid;

    saqfc_nfifo #(.W(ENT_W), .DEPTH(NQ_DEPTH)) u_nq (
        .clk        (clk),
        .rst_n      (rst_n),
        .push_a     (push_a),
        .data_a     (data_a),
        .push_b     (push_b),
        .data_b     (data_b),
        .pop        (pop),
        .head_valid (nt_valid),
        .head_data  (head),
        .level      (fq_level)
    );

    assign nt_xon     = head[KEY_W];
    assign nt_key     = head[KEY_W-1:0];
    assign line_valid = ln_valid;
    assign line_stop  = ln_stop;

endmodule

// File: rtl/saqfc_chk.sv
module saqfc_chk #(
    parameter int NLINES   = 4,
    parameter int KEY_W    = 8,
    parameter int CNT_W    = 7,
    parameter int XOFF_TH  = 10,
    parameter int NQ_DEPTH = 4,
    localparam int IDX_W = $clog2(NLINES),
    localparam int LVL_W = $clog2(NQ_DEPTH + 1)
) (
    input logic              clk,
    input logic              rst_n,
    input logic              mv_valid,
    input logic              mv_dst_saq,
    input logic [IDX_W-1:0]  mv_dst_idx,
    input logic [CNT_W-1:0]  mv_dst_cnt,
    input logic              loc_valid,
    input logic              loc_is_xon,
    input logic [KEY_W-1:0]  loc_key,
    input logic [NLINES-1:0] line_valid,
    input logic [NLINES-1:0] line_stop,
    input logic [NLINES-1:0] line_sent,
    input logic [KEY_W-1:0]  line_key [NLINES],
    input logic              nt_valid,
    input logic              nt_ready,
    input logic              nt_xon,
    input logic [KEY_W-1:0]  nt_key,
    input logic [LVL_W-1:0]  level
);

    for (genvar i = 0; i < NLINES; i++) begin : g_ln
        AST_XOFF_SETS_STOP: assert property (@(posedge clk) disable iff (!rst_n)
            (loc_valid && !loc_is_xon && line_valid[i] && line_key[i] == loc_key) |=> line_stop[i]); // R5
        AST_XON_CLEARS_STOP: assert property (@(posedge clk) disable iff (!rst_n)
            (loc_valid && loc_is_xon && line_valid[i] && line_key[i] == loc_key) |=> !line_stop[i]); // R6
        AST_NO_FREE_HALTED: assert property (@(posedge clk) disable iff (!rst_n)
            $fell(line_valid[i]) |-> $past(!line_stop[i])); // R8
        AST_RELEASE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
            $fell(line_valid[i]) |-> $past(!mv_valid && !loc_valid)); // R9
        AST_SENT_ON_XOFF: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(line_sent[i]) |-> $past(mv_valid && mv_dst_saq && mv_dst_idx == IDX_W'(i)
                                          && mv_dst_cnt > CNT_W'(XOFF_TH))); // R1
    end

    AST_HEAD_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (nt_valid && !nt_ready) |=> (nt_valid && $stable(nt_xon) && $stable(nt_key))); // R10
    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        level <= LVL_W'(NQ_DEPTH)); // R10

endmodule

bind saqfc_ctrl saqfc_chk #(
    .NLINES(NLINES), .KEY_W(KEY_W), .CNT_W(CNT_W), .XOFF_TH(XOFF_TH), .NQ_DEPTH(NQ_DEPTH)
) u_chk (
    .clk(clk), .rst_n(rst_n), .mv_valid(mv_valid), .mv_dst_saq(mv_dst_saq),
    .mv_dst_idx(mv_dst_idx), .mv_dst_cnt(mv_dst_cnt), .loc_valid(loc_valid),
    .loc_is_xon(loc_is_xon), .loc_key(loc_key), .line_valid(line_valid),
    .line_stop(line_stop), .line_sent(ln_sent), .line_key(ln_key),
    .nt_valid(nt_valid), .nt_ready(nt_ready), .nt_xon(nt_xon), .nt_key(nt_key),
    .level(fq_level)
);

// File: tb/saqfc_ctrl_tb.sv
module saqfc_ctrl_tb;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       mv_valid = 1'b0, mv_dst_saq = 1'b0, mv_src_saq = 1'b0;
    logic [1:0] mv_dst_idx = '0, mv_src_idx = '0, dl_idx = '0;
    logic [6:0] mv_dst_cnt = '0, mv_src_cnt = '0;
    logic       loc_valid = 1'b0, loc_is_xon = 1'b0, alloc_valid = 1'b0, dl_valid = 1'b0;
    logic [7:0] loc_key = '0, alloc_key = '0;
    logic       nt_ready = 1'b0;
    logic [3:0] line_valid, line_stop;
    logic       nt_valid, nt_xon;
    logic [7:0] nt_key;

    int total = 0;
    int bad = 0;
    bit done = 0;

    always #5 clk = ~clk;

    saqfc_ctrl u_dut (
        .clk(clk), .rst_n(rst_n), .mv_valid(mv_valid), .mv_dst_saq(mv_dst_saq),
        .mv_dst_idx(mv_dst_idx), .mv_dst_cnt(mv_dst_cnt), .mv_src_saq(mv_src_saq),
        .mv_src_idx(mv_src_idx), .mv_src_cnt(mv_src_cnt), .loc_valid(loc_valid),
        .loc_is_xon(loc_is_xon), .loc_key(loc_key), .alloc_valid(alloc_valid),
        .alloc_key(alloc_key), .dl_valid(dl_valid), .dl_idx(dl_idx), .nt_ready(nt_ready),
        .line_valid(line_valid), .line_stop(line_stop), .nt_valid(nt_valid),
        .nt_xon(nt_xon), .nt_key(nt_key)
    );

    // dsaq,didx,dcnt,ssaq,sidx,scnt,n,x0,k0,x1,k1,req
    typedef struct packed {
        logic dsaq; logic [1:0] didx; logic [6:0] dcnt;
        logic ssaq; logic [1:0] sidx; logic [6:0] scnt;
        logic [1:0] n; logic x0; logic [7:0] k0; logic x1; logic [7:0] k1;
        logic [3:0] rq;
    } vec_t;

    localparam vec_t VECS [10] = '{
        '{1'b1, 2'd0, 7'd10, 1'b0, 2'd0, 7'd0, 2'd0, 1'b0, 8'h00, 1'b0, 8'h00, 4'd2}, // R2 equal mark
        '{1'b1, 2'd0, 7'd11, 1'b0, 2'd0, 7'd0, 2'd1, 1'b0, 8'h11, 1'b0, 8'h00, 4'd1}, // R1
        '{1'b1, 2'd0, 7'd12, 1'b0, 2'd0, 7'd0, 2'd0, 1'b0, 8'h00, 1'b0, 8'h00, 4'd2}, // R2 already sent
        '{1'b0, 2'd0, 7'd20, 1'b1, 2'd0, 7'd6, 2'd0, 1'b0, 8'h00, 1'b0, 8'h00, 4'd3}, // R3 not below
        '{1'b0, 2'd0, 7'd3,  1'b1, 2'd0, 7'd5, 2'd0, 1'b0, 8'h00, 1'b0, 8'h00, 4'd3}, // R3 equal mark
        '{1'b0, 2'd0, 7'd3,  1'b1, 2'd0, 7'd4, 2'd1, 1'b1, 8'h11, 1'b0, 8'h00, 4'd3}, // R3
        '{1'b0, 2'd0, 7'd3,  1'b1, 2'd0, 7'd3, 2'd0, 1'b0, 8'h00, 1'b0, 8'h00, 4'd3}, // R3 flag clear
        '{1'b1, 2'd1, 7'd11, 1'b1, 2'd0, 7'd2, 2'd1, 1'b0, 8'h22, 1'b0, 8'h00, 4'd1}, // R1
        '{1'b1, 2'd2, 7'd15, 1'b1, 2'd1, 7'd0, 2'd2, 1'b0, 8'h33, 1'b1, 8'h22, 4'd4}, // R4
        '{1'b0, 2'd0, 7'd50, 1'b0, 2'd1, 7'd0, 2'd0, 1'b0, 8'h00, 1'b0, 8'h00, 4'd2}  // R2 cold queue
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic step;
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic do_move(input logic ds, input logic [1:0] di, input logic [6:0] dc,
                           input logic ss, input logic [1:0] si, input logic [6:0] sc);
        mv_valid = 1'b1; mv_dst_saq = ds; mv_dst_idx = di; mv_dst_cnt = dc;
        mv_src_saq = ss; mv_src_idx = si; mv_src_cnt = sc;
        step();
        mv_valid = 1'b0;
    endtask

    task automatic do_loc(input logic xon, input logic [7:0] k);
        loc_valid = 1'b1; loc_is_xon = xon; loc_key = k;
        step();
        loc_valid = 1'b0;
    endtask

    task automatic do_alloc(input logic [7:0] k);
        alloc_valid = 1'b1; alloc_key = k;
        step();
        alloc_valid = 1'b0;
    endtask

    task automatic do_rel(input logic [1:0] i);
        dl_valid = 1'b1; dl_idx = i;
        step();
        dl_valid = 1'b0;
    endtask

    task automatic take(input string req, input logic xon, input logic [7:0] k);
        chk(req, {31'd0, nt_valid}, 32'd1);
        chk(req, {31'd0, nt_xon}, {31'd0, xon});
        chk(req, {24'd0, nt_key}, {24'd0, k});
        nt_ready = 1'b1;
        step();
        nt_ready = 1'b0;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        chk("R11 valid", {28'd0, line_valid}, 32'd0);
        chk("R11 stop", {28'd0, line_stop}, 32'd0);
        chk("R11 notice", {31'd0, nt_valid}, 32'd0);
        rst_n = 1'b1;
        step();

        // R7: claim three lines
        do_alloc(8'h11); do_alloc(8'h22); do_alloc(8'h33);
        chk("R7 claim", {28'd0, line_valid}, 32'h7);
        chk("R7 running", {28'd0, line_stop}, 32'h0);

        foreach (VECS[v]) begin
            do_move(VECS[v].dsaq, VECS[v].didx, VECS[v].dcnt,
                    VECS[v].ssaq, VECS[v].sidx, VECS[v].scnt);
            if (VECS[v].n >= 2'd1) take($sformatf("R%0d vec%0d", VECS[v].rq, v), VECS[v].x0, VECS[v].k0);
            if (VECS[v].n == 2'd2) take($sformatf("R%0d vec%0d", VECS[v].rq, v), VECS[v].x1, VECS[v].k1);
            chk($sformatf("R%0d vec%0d empty", VECS[v].rq, v), {31'd0, nt_valid}, 32'd0);
        end

        do_alloc(8'h22);
        chk("R7 duplicate", {28'd0, line_valid}, 32'h7);
        do_loc(1'b0, 8'h22);
        chk("R5 halt match", {28'd0, line_stop}, 32'h2);
        do_rel(2'd1);
        chk("R8 halted release", {28'd0, line_valid}, 32'h7);
        do_loc(1'b1, 8'h22);
        chk("R6 go", {28'd0, line_stop}, 32'h0);
        do_loc(1'b0, 8'h44);
        chk("R5 new halted valid", {28'd0, line_valid}, 32'hF);
        chk("R5 new halted stop", {28'd0, line_stop}, 32'h8);
        do_loc(1'b0, 8'h55);
        chk("R5 table full", {28'd0, line_valid}, 32'hF);
        chk("R5 table full stop", {28'd0, line_stop}, 32'h8);

        // R9: release blocked by a move in the same cycle
        dl_valid = 1'b1; dl_idx = 2'd0;
        do_move(1'b0, 2'd0, 7'd1, 1'b0, 2'd0, 7'd1);
        dl_valid = 1'b0;
        chk("R9 blocked", {28'd0, line_valid}, 32'hF);
        do_rel(2'd2);
        chk("R9 freed", {28'd0, line_valid}, 32'hB);
        take("R9 owed go", 1'b1, 8'h33);

        // R7: claim blocked by a local notice in the same cycle
        alloc_valid = 1'b1; alloc_key = 8'h66;
        do_loc(1'b1, 8'h99);
        alloc_valid = 1'b0;
        chk("R7 blocked", {28'd0, line_valid}, 32'hB);
        do_alloc(8'h66);
        chk("R7 refill", {28'd0, line_valid}, 32'hF);
        chk("R7 refill stop", {28'd0, line_stop}, 32'h8);

        // R10: fill the notice queue, then a dropped stop is retried
        do_move(1'b1, 2'd0, 7'd11, 1'b0, 2'd0, 7'd0);
        do_move(1'b0, 2'd0, 7'd0, 1'b1, 2'd0, 7'd0);
        do_move(1'b1, 2'd0, 7'd11, 1'b0, 2'd0, 7'd0);
        do_move(1'b0, 2'd0, 7'd0, 1'b1, 2'd0, 7'd0);
        do_move(1'b1, 2'd0, 7'd11, 1'b0, 2'd0, 7'd0);
        take("R10 order 0", 1'b0, 8'h11);
        take("R10 order 1", 1'b1, 8'h11);
        take("R10 order 2", 1'b0, 8'h11);
        take("R10 order 3", 1'b1, 8'h11);
        chk("R10 no extra", {31'd0, nt_valid}, 32'd0);
        do_move(1'b1, 2'd0, 7'd11, 1'b0, 2'd0, 7'd0);
        take("R10 retry", 1'b0, 8'h11);

        done = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule